// File: doc/BRIEF.md
# DMA Unit Cycle-Cost Calculator

This block tells a DMA channel how many bus cycles each halfword it moves will cost. For every unit the channel presents the current source and destination addresses, whether each address steps upward, and whether this unit opens a new burst. The block looks up both endpoints in a small programmable window table, classifies the pair, and returns the cost one clock later with a valid strobe.

The window table holds one entry per 16 KB address window. Each entry gives a one-hot region code plus a non-sequential and a sequential access cost. When main memory is read or written with an upward-stepping address, the cost comes from a per-unit burst schedule held in a ROM. The schedule is chosen by the region and sequential cost of the other endpoint. It runs until it reaches a zero terminator or a new burst begins, and then starts again. Every other pairing of regions is priced by a short additive formula. The channel controller pulses a start input at the beginning of each channel run, so that the first burst unit always picks a fresh schedule.

Top module: `dma_unit_cost`

## Requirements
- R1: An endpoint's table entry is picked by address bits [14 +: WIN_BITS] (bits [17:14] by default). Higher address bits and bits below 14 play no part in the choice. The table entry written through the cfg port with cfg_idx = w serves every address in window w.
- R2: When the source and the destination both carry the main-memory code (MAIN_CODE, default 4'b0001), each unit costs exactly 16.
- R3: When the source is main memory, the source steps upward and the destination is not main memory, the cost is the read schedule entry at the current pointer, and the pointer then moves up by one. Read schedule 1 is used when the destination is cartridge ROM (CART_CODE, default 4'b1000) with a sequential cost of 4. Read schedule 2 is used for cartridge ROM with any other sequential cost. Read schedule 0 is used for every other destination.
- R4: The pointer returns to entry 0 and the schedule is chosen again when burst_start is high or when the entry at the pointer is 0. A pulse on chan_start makes the next scheduled unit restart in the same way.
- R5: When the source is main memory stepping down or holding, the cost is 7 if src_addr[4:0] = 5'h1E and 8 otherwise. To this is added the destination's non-sequential cost when burst_start is high, or its sequential cost when it is low.
- R6: When only the destination is main memory and it steps upward, the cost comes from a write schedule. The write schedule is chosen by the same cartridge-ROM rule as in R3, applied to the source region and the source's sequential cost.
- R7: When only the destination is main memory and it does not step upward, the cost is 7 plus the source's non-sequential cost (burst_start high) or the source's sequential cost (burst_start low).
- R8: When neither endpoint is main memory and the two region codes share a set bit, the cost is src_n + dst_n + 1, whatever the state of burst_start.
- R9: For any other pairing, the cost is src_n + dst_n when burst_start is high and src_s + dst_s when it is low.
- R10: cost_valid is high in the cycle after each cycle in which unit_req is high, and low otherwise. cost carries the result of that request. After reset, cost_valid is 0 and cost is 0.
- R11: Each schedule has RD_LEN (read) or WR_LEN (write) entries and then zeros. The read schedules are: 0 = 7, 3, then 2s; 1 = 9, then 4s; 2 = 12, then 6s. The write schedules are: 0 = 8, then 2s; 1 = 9, then 3s; 2 = 11, then 5s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one window table entry |
| cfg_idx | input | WIN_BITS | Window number to write |
| cfg_region | input | REG_W | One-hot region code of the window |
| cfg_ncost | input | COST_W | Non-sequential access cost of the window |
| cfg_scost | input | COST_W | Sequential access cost of the window |
| chan_start | input | 1 | Channel start pulse; drops the current burst schedule |
| unit_req | input | 1 | Request the cost of one unit |
| burst_start | input | 1 | This unit opens a burst |
| src_addr | input | 32 | Current source address |
| dst_addr | input | 32 | Current destination address |
| src_inc | input | 1 | Source address steps upward |
| dst_inc | input | 1 | Destination address steps upward |
| cost | output | COST_W+2 | Cycle cost of the last requested unit |
| cost_valid | output | 1 | cost belongs to the request of the previous cycle |

## Verification
The bench uses the default parameters: WIN_BITS = 4, RD_LEN = 10, WR_LEN = 6, DEPTH = 16. With these, sixteen windows are enough to place main memory, two cartridge ROM variants and three ordinary regions side by side, and address bit 20 lies above the decoded field. The short schedule lengths mean that a run of a dozen units walks through a whole read schedule and past its zero terminator. The bench therefore sees a restart triggered by the terminator as well as one triggered by burst_start, and it also sees a write schedule wrap.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_RD   = 2'd1,
    BK_WR   = 2'd2
  } burst_kind_e;

  // Entry idx of schedule sel of the given kind; zero past the active length.
  function automatic logic [7:0] burst_entry(input burst_kind_e kind,
                                             input int sel, input int idx,
                                             input int rd_len, input int wr_len);
    int len;
    int first;
    int rest;
    len   = (kind == BK_RD) ? rd_len : wr_len;
    first = 0;
    rest  = 0;
    if (kind == BK_RD) begin
      case (sel)
        0: begin first = 7;  rest = 2; end
        1: begin first = 9;  rest = 4; end
        2: begin first = 12; rest = 6; end
        default: len = 0;
      endcase
    end else if (kind == BK_WR) begin
      case (sel)
        0: begin first = 8;  rest = 2; end
        1: begin first = 9;  rest = 3; end
        2: begin first = 11; rest = 5; end
        default: len = 0;
      endcase
    end else begin
      len = 0;
    end
    if (idx >= len)                           return 8'd0;
    if (idx == 0)                             return 8'(first);
    if (kind == BK_RD && sel == 0 && idx == 1) return 8'd3;
    return 8'(rest);
  endfunction

endpackage

// File: rtl/dmc_win_table.sv
module dmc_win_table #(
  parameter int WIN_BITS = 4,
  parameter int REG_W    = 4,
  parameter int COST_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WIN_BITS-1:0] wr_idx,
  input  logic [REG_W-1:0]    wr_region,
  input  logic [COST_W-1:0]   wr_ncost,
  input  logic [COST_W-1:0]   wr_scost,
  input  logic [WIN_BITS-1:0] src_idx,
  input  logic [WIN_BITS-1:0] dst_idx,
  output logic [REG_W-1:0]    src_region,
  output logic [COST_W-1:0]   src_n,
  output logic [COST_W-1:0]   src_s,
  output logic [REG_W-1:0]    dst_region,
  output logic [COST_W-1:0]   dst_n,
  output logic [COST_W-1:0]   dst_s
);
  localparam int WINS = 1 << WIN_BITS;

  logic [REG_W-1:0]  region_q [WINS];
  logic [COST_W-1:0] ncost_q  [WINS];
  logic [COST_W-1:0] scost_q  [WINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WINS; w++) begin
        region_q[w] <= '0;
        ncost_q[w]  <= '0;
        scost_q[w]  <= '0;
      end
    end else if (wr_en) begin
      region_q[wr_idx] <= wr_region;
      ncost_q[wr_idx]  <= wr_ncost;
      scost_q[wr_idx]  <= wr_scost;
    end
  end

  assign src_region = region_q[src_idx];
  assign src_n      = ncost_q[src_idx];
  assign src_s      = scost_q[src_idx];
  assign dst_region = region_q[dst_idx];
  assign dst_n      = ncost_q[dst_idx];
  assign dst_s      = scost_q[dst_idx];
endmodule

// File: rtl/dmc_burst_rom.sv
module dmc_burst_rom #(
  parameter int DEPTH  = 16,
  parameter int RD_LEN = 10,
  parameter int WR_LEN = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  dmc_pkg::burst_kind_e a_kind,
  input  logic [1:0]           a_sel,
  input  logic [PTR_W-1:0]     a_idx,
  output logic [7:0]           a_val,
  input  dmc_pkg::burst_kind_e b_kind,
  input  logic [1:0]           b_sel,
  input  logic [PTR_W-1:0]     b_idx,
  output logic [7:0]           b_val
);
  import dmc_pkg::*;

  // [0] = read schedules, [1] = write schedules
  logic [7:0] rom [2][4][DEPTH];

  for (genvar k = 0; k < 2; k++) begin : g_kind
    for (genvar s = 0; s < 4; s++) begin : g_sel
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign rom[k][s][i] = burst_entry((k == 0) ? BK_RD : BK_WR, s, i, RD_LEN, WR_LEN);
      end
    end
  end

  assign a_val = (a_kind == BK_NONE) ? 8'd0 : rom[a_kind == BK_WR][a_sel][a_idx];
  assign b_val = (b_kind == BK_NONE) ? 8'd0 : rom[b_kind == BK_WR][b_sel][b_idx];
endmodule

// File: rtl/dmc_burst_seq.sv
module dmc_burst_seq #(
  parameter int DEPTH  = 16,
  parameter int RD_LEN = 10,
  parameter int WR_LEN = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 chan_start,
  input  logic                 req,
  input  logic                 bstart,
  input  dmc_pkg::burst_kind_e mode,
  input  logic [1:0]           rd_sel,
  input  logic [1:0]           wr_sel,
  output logic [7:0]           burst_cost,
  output logic [PTR_W-1:0]     ptr
);
  import dmc_pkg::*;

  burst_kind_e      kind_q;
  logic [1:0]       sel_q;
  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       cur_val;
  logic [7:0]       first_val;
  logic [1:0]       new_sel;
  logic             restart;

  dmc_burst_rom #(.DEPTH(DEPTH), .RD_LEN(RD_LEN), .WR_LEN(WR_LEN)) u_rom (
    .a_kind (kind_q),
    .a_sel  (sel_q),
    .a_idx  (ptr_q),
    .a_val  (cur_val),
    .b_kind (mode),
    .b_sel  (new_sel),
    .b_idx  ('0),
    .b_val  (first_val)
  );

  always_comb begin
    new_sel    = (mode == BK_WR) ? wr_sel : rd_sel;
    restart    = bstart || (cur_val == 8'd0);
    burst_cost = restart ? first_val : cur_val;
  end

  always_ff @(posedge clk) begin
    if (rst || chan_start) begin
      kind_q <= BK_NONE;
      sel_q  <= '0;
      ptr_q  <= '0;
    end else if (req && mode != BK_NONE) begin
      if (restart) begin
        kind_q <= mode;
        sel_q  <= new_sel;
        ptr_q  <= PTR_W'(1);
      end else begin
        ptr_q  <= ptr_q + PTR_W'(1);
      end
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/dmc_cost_sel.sv
module dmc_cost_sel #(
  parameter int REG_W             = 4,
  parameter int COST_W            = 8,
  parameter logic [REG_W-1:0] MAIN_CODE = 4'b0001,
  parameter logic [REG_W-1:0] CART_CODE = 4'b1000,
  parameter int CART_FAST_S       = 4,
  localparam int OUT_W            = COST_W + 2
) (
  input  logic [REG_W-1:0]     src_region,
  input  logic [COST_W-1:0]    src_n,
  input  logic [COST_W-1:0]    src_s,
  input  logic [REG_W-1:0]     dst_region,
  input  logic [COST_W-1:0]    dst_n,
  input  logic [COST_W-1:0]    dst_s,
  input  logic                 src_inc,
  input  logic                 dst_inc,
  input  logic                 bstart,
  input  logic [4:0]           src_lo,
  input  logic [7:0]           burst_cost,
  output dmc_pkg::burst_kind_e mode,
  output logic [1:0]           rd_sel,
  output logic [1:0]           wr_sel,
  output logic [OUT_W-1:0]     cost
);
  import dmc_pkg::*;

  logic src_main, dst_main;

  function automatic logic [1:0] pick(input logic [REG_W-1:0] rg, input logic [COST_W-1:0] sc);
    if (rg != CART_CODE)             return 2'd0;
    if (sc == COST_W'(CART_FAST_S))  return 2'd1;
    return 2'd2;
  endfunction

  always_comb begin
    src_main = (src_region == MAIN_CODE);
    dst_main = (dst_region == MAIN_CODE);
    rd_sel   = pick(dst_region, dst_s);
    wr_sel   = pick(src_region, src_s);
    mode     = BK_NONE;
    if (src_main && dst_main) begin
      cost = OUT_W'(16);
    end else if (src_main && src_inc) begin
      mode = BK_RD;
      cost = OUT_W'(burst_cost);
    end else if (src_main) begin
      cost = ((src_lo == 5'h1E) ? OUT_W'(7) : OUT_W'(8)) +
             OUT_W'(bstart ? dst_n : dst_s);
    end else if (dst_main && dst_inc) begin
      mode = BK_WR;
      cost = OUT_W'(burst_cost);
    end else if (dst_main) begin
      cost = OUT_W'(bstart ? src_n : src_s) + OUT_W'(7);
    end else if ((src_region & dst_region) != '0) begin
      cost = OUT_W'(src_n) + OUT_W'(dst_n) + OUT_W'(1);
    end else if (bstart) begin
      cost = OUT_W'(src_n) + OUT_W'(dst_n);
    end else begin
      cost = OUT_W'(src_s) + OUT_W'(dst_s);
    end
  end
endmodule

// File: rtl/dma_unit_cost.sv
module dma_unit_cost #(
  parameter int WIN_BITS          = 4,
  parameter int REG_W             = 4,
  parameter int COST_W            = 8,
  parameter int DEPTH             = 16,
  parameter int RD_LEN            = 10,
  parameter int WR_LEN            = 6,
  parameter logic [REG_W-1:0] MAIN_CODE = 4'b0001,
  parameter logic [REG_W-1:0] CART_CODE = 4'b1000,
  parameter int CART_FAST_S       = 4,
  localparam int OUT_W            = COST_W + 2,
  localparam int PTR_W            = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [WIN_BITS-1:0] cfg_idx,
  input  logic [REG_W-1:0]    cfg_region,
  input  logic [COST_W-1:0]   cfg_ncost,
  input  logic [COST_W-1:0]   cfg_scost,
  input  logic                chan_start,
  input  logic                unit_req,
  input  logic                burst_start,
  input  logic [31:0]         src_addr,
  input  logic [31:0]         dst_addr,
  input  logic                src_inc,
  input  logic                dst_inc,
  output logic [OUT_W-1:0]    cost,
  output logic                cost_valid
);
  import dmc_pkg::*;

  logic [REG_W-1:0]  src_region, dst_region;
  logic [COST_W-1:0] src_n, src_s, dst_n, dst_s;
  logic [7:0]        burst_cost;
  burst_kind_e       mode;
  logic [1:0]        rd_sel, wr_sel;
  logic [OUT_W-1:0]  cost_d;
  logic [PTR_W-1:0]  seq_ptr;

  wire unused_addr = ^{src_addr[13:5], src_addr[31:14+WIN_BITS],
                       dst_addr[13:0], dst_addr[31:14+WIN_BITS]};

  dmc_win_table #(.WIN_BITS(WIN_BITS), .REG_W(REG_W), .COST_W(COST_W)) u_tab (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_we),
    .wr_idx     (cfg_idx),
    .wr_region  (cfg_region),
    .wr_ncost   (cfg_ncost),
    .wr_scost   (cfg_scost),
    .src_idx    (src_addr[14 +: WIN_BITS]),
    .dst_idx    (dst_addr[14 +: WIN_BITS]),
    .src_region (src_region),
    .src_n      (src_n),
    .src_s      (src_s),
    .dst_region (dst_region),
    .dst_n      (dst_n),
    .dst_s      (dst_s)
  );

  dmc_cost_sel #(.REG_W(REG_W), .COST_W(COST_W), .MAIN_CODE(MAIN_CODE),
                 .CART_CODE(CART_CODE), .CART_FAST_S(CART_FAST_S)) u_sel (
    .src_region (src_region),
    .src_n      (src_n),
    .src_s      (src_s),
    .dst_region (dst_region),
    .dst_n      (dst_n),
    .dst_s      (dst_s),
    .src_inc    (src_inc),
    .dst_inc    (dst_inc),
    .bstart     (burst_start),
    .src_lo     (src_addr[4:0]),
    .burst_cost (burst_cost),
    .mode       (mode),
    .rd_sel     (rd_sel),
    .wr_sel     (wr_sel),
    .cost       (cost_d)
  );

  dmc_burst_seq #(.DEPTH(DEPTH), .RD_LEN(RD_LEN), .WR_LEN(WR_LEN)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .chan_start (chan_start),
    .req        (unit_req),
    .bstart     (burst_start),
    .mode       (mode),
    .rd_sel     (rd_sel),
    .wr_sel     (wr_sel),
    .burst_cost (burst_cost),
    .ptr        (seq_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cost       <= '0;
      cost_valid <= 1'b0;
    end else begin
      cost_valid <= unit_req;
      if (unit_req) cost <= cost_d;
    end
  end
endmodule

// File: rtl/dma_unit_cost_chk.sv
module dma_unit_cost_chk #(
  parameter int REG_W  = 4,
  parameter int COST_W = 8,
  parameter int PTR_W  = 4,
  parameter logic [REG_W-1:0] MAIN_CODE = 4'b0001,
  localparam int OUT_W = COST_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              chan_start,
  input logic              unit_req,
  input logic              burst_start,
  input logic              src_inc,
  input logic              dst_inc,
  input logic [REG_W-1:0]  src_region,
  input logic [REG_W-1:0]  dst_region,
  input logic [COST_W-1:0] src_n,
  input logic [PTR_W-1:0]  seq_ptr,
  input logic [OUT_W-1:0]  cost,
  input logic              cost_valid
);
  wire sm = (src_region == MAIN_CODE);
  wire dm = (dst_region == MAIN_CODE);

  a_r10_valid_next: assert property (@(posedge clk) disable iff (rst)
    unit_req |=> cost_valid);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !unit_req |=> !cost_valid);
  a_r2_main_pair: assert property (@(posedge clk) disable iff (rst)
    unit_req && sm && dm |=> cost == OUT_W'(16));
  a_r4_burst_restart: assert property (@(posedge clk) disable iff (rst)
    unit_req && burst_start && sm && !dm && src_inc && !chan_start |=> seq_ptr == PTR_W'(1));
  a_r4_chan_clear: assert property (@(posedge clk) disable iff (rst)
    chan_start |=> seq_ptr == '0);
  a_r7_dst_down: assert property (@(posedge clk) disable iff (rst)
    unit_req && !sm && dm && !dst_inc && burst_start |=>
      cost == OUT_W'($past(src_n)) + OUT_W'(7));
endmodule

bind dma_unit_cost dma_unit_cost_chk #(
  .REG_W(REG_W), .COST_W(COST_W), .PTR_W(PTR_W), .MAIN_CODE(MAIN_CODE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .chan_start  (chan_start),
  .unit_req    (unit_req),
  .burst_start (burst_start),
  .src_inc     (src_inc),
  .dst_inc     (dst_inc),
  .src_region  (src_region),
  .dst_region  (dst_region),
  .src_n       (src_n),
  .seq_ptr     (seq_ptr),
  .cost        (cost),
  .cost_valid  (cost_valid)
);

// File: tb/dma_unit_cost_bench.sv
module dma_unit_cost_bench;
  localparam int RD_LEN = 10;
  localparam int WR_LEN = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [3:0] cfg_region = '0;
  logic [7:0] cfg_ncost = '0;
  logic [7:0] cfg_scost = '0;
  logic       chan_start = 1'b0;
  logic       unit_req = 1'b0;
  logic       burst_start = 1'b0;
  logic [31:0] src_addr = '0;
  logic [31:0] dst_addr = '0;
  logic       src_inc = 1'b0;
  logic       dst_inc = 1'b0;
  logic [9:0] cost;
  logic       cost_valid;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int m_reg [16];
  int m_n   [16];
  int m_s   [16];
  int mk = 0, ms = 0, mp = 0;

  always #5 clk = ~clk;

  dma_unit_cost #(.RD_LEN(RD_LEN), .WR_LEN(WR_LEN)) u_dma_unit_cost (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_region(cfg_region), .cfg_ncost(cfg_ncost), .cfg_scost(cfg_scost),
    .chan_start(chan_start), .unit_req(unit_req), .burst_start(burst_start),
    .src_addr(src_addr), .dst_addr(dst_addr), .src_inc(src_inc), .dst_inc(dst_inc),
    .cost(cost), .cost_valid(cost_valid)
  );

  task automatic check(input string rq, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  // schedule contents as listed in R11
  function automatic int sched(input int k, input int s, input int i);
    int len;
    if (k == 0) return 0;
    len = (k == 1) ? RD_LEN : WR_LEN;
    if (i >= len) return 0;
    if (k == 1) begin
      if (s == 0) return (i == 0) ? 7 : ((i == 1) ? 3 : 2);
      if (s == 1) return (i == 0) ? 9 : 4;
      return (i == 0) ? 12 : 6;
    end
    if (s == 0) return (i == 0) ? 8 : 2;
    if (s == 1) return (i == 0) ? 9 : 3;
    return (i == 0) ? 11 : 5;
  endfunction

  function automatic int choose(input int rg, input int sc);
    if (rg != 8) return 0;
    return (sc == 4) ? 1 : 2;
  endfunction

  task automatic cfg(input int w, input int rg, input int n, input int s);
    cfg_we = 1'b1; cfg_idx = 4'(w); cfg_region = 4'(rg);
    cfg_ncost = 8'(n); cfg_scost = 8'(s);
    @(negedge clk);
    cfg_we = 1'b0;
    m_reg[w] = rg; m_n[w] = n; m_s[w] = s;
  endtask

  task automatic new_channel();
    chan_start = 1'b1;
    @(negedge clk);
    chan_start = 1'b0;
    mk = 0; mp = 0;
  endtask

  task automatic unit(input string rq, input logic [31:0] sa, input logic [31:0] da,
                      input bit si, input bit di, input bit bs);
    int sw, dw, sr, dr, e, k, sel, cur;
    bit smain, dmain;
    sw = int'(sa[17:14]); dw = int'(da[17:14]);
    sr = m_reg[sw]; dr = m_reg[dw];
    smain = (sr == 1); dmain = (dr == 1);
    k = 0; sel = 0;
    if (smain && dmain)            e = 16;
    else if (smain && si)          begin k = 1; sel = choose(dr, m_s[dw]); end
    else if (smain)                e = ((sa[4:0] == 5'h1E) ? 7 : 8) + (bs ? m_n[dw] : m_s[dw]);
    else if (dmain && di)          begin k = 2; sel = choose(sr, m_s[sw]); end
    else if (dmain)                e = (bs ? m_n[sw] : m_s[sw]) + 7;
    else if ((sr & dr) != 0)       e = m_n[sw] + m_n[dw] + 1;
    else if (bs)                   e = m_n[sw] + m_n[dw];
    else                           e = m_s[sw] + m_s[dw];
    if (k != 0) begin
      cur = sched(mk, ms, mp);
      if (bs || cur == 0) begin
        mk = k; ms = sel; mp = 0;
        cur = sched(mk, ms, 0);
      end
      e = cur;
      mp++;
    end
    unit_req = 1'b1; burst_start = bs; src_addr = sa; dst_addr = da;
    src_inc = si; dst_inc = di;
    @(negedge clk);
    unit_req = 1'b0; burst_start = 1'b0;
    check({rq, " valid"}, int'(cost_valid), 1);
    check(rq, int'(cost), e);
  endtask

  function automatic logic [31:0] wa(input int w, input int off);
    return (32'(w) << 14) | 32'(off);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_reg[i] = 0; m_n[i] = 0; m_s[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset valid", int'(cost_valid), 0);
    check("R10 reset cost", int'(cost), 0);

    cfg(0, 1, 9, 2);   // main memory
    cfg(1, 8, 6, 4);   // cartridge, fast sequential
    cfg(2, 8, 10, 6);  // cartridge, slow sequential
    cfg(3, 2, 3, 1);
    cfg(4, 2, 5, 2);   // shares a bit with window 3
    cfg(5, 4, 4, 3);
    new_channel();

    unit("R2 main to main", wa(0, 0), wa(0, 'h100), 1, 1, 1);
    unit("R2 main to main seq", wa(0, 2), wa(0, 'h102), 1, 1, 0);

    // R3/R11: read schedule 0 through its terminator, R4 restart on zero entry
    for (int i = 0; i < RD_LEN + 3; i++)
      unit("R3 R4 read sched 0", wa(0, 2 * i), wa(5, 2 * i), 1, 1, i == 0);
    unit("R4 restart on burst_start", wa(0, 0), wa(5, 0), 1, 1, 1);
    for (int i = 0; i < 3; i++)
      unit("R3 read sched 1", wa(0, 2 * i), wa(1, 2 * i), 1, 1, i == 0);
    for (int i = 0; i < 3; i++)
      unit("R3 read sched 2", wa(0, 2 * i), wa(2, 2 * i), 1, 1, i == 0);

    // R4: channel start drops the schedule mid-burst
    unit("R3 before channel start", wa(0, 6), wa(2, 6), 1, 1, 0);
    new_channel();
    unit("R4 after channel start", wa(0, 8), wa(2, 8), 1, 1, 0);

    unit("R5 down src low 1E bs", wa(0, 'h3E), wa(5, 0), 0, 1, 1);
    unit("R5 down src other seq", wa(0, 'h3C), wa(1, 0), 0, 1, 0);
    unit("R5 down src 1E seq", wa(0, 'h1E), wa(2, 0), 0, 0, 0);

    for (int i = 0; i < WR_LEN + 2; i++)
      unit("R6 R11 write sched 0", wa(3, 2 * i), wa(0, 2 * i), 1, 1, i == 0);
    for (int i = 0; i < 2; i++)
      unit("R6 write sched 1", wa(1, 2 * i), wa(0, 2 * i), 1, 1, i == 0);
    for (int i = 0; i < 2; i++)
      unit("R6 write sched 2", wa(2, 2 * i), wa(0, 2 * i), 1, 1, i == 0);

    unit("R7 dst down bs", wa(2, 0), wa(0, 0), 1, 0, 1);
    unit("R7 dst down seq", wa(2, 2), wa(0, 0), 1, 0, 0);

    unit("R8 shared bit bs", wa(3, 0), wa(4, 0), 1, 1, 1);
    unit("R8 shared bit seq", wa(4, 0), wa(3, 0), 1, 1, 0);
    unit("R9 disjoint bs", wa(3, 0), wa(5, 0), 1, 1, 1);
    unit("R9 disjoint seq", wa(5, 0), wa(1, 0), 0, 0, 0);

    // R1: bit 20 lies above the decoded field
    cfg(6, 2, 7, 3);
    unit("R1 high bits ignored", 32'h0010_0000 | wa(6, 'h3FFE), wa(5, 0), 1, 1, 1);
    cfg(6, 4, 2, 1);
    unit("R1 rewritten window", 32'h0010_0000 | wa(6, 0), wa(3, 0), 1, 1, 1);

    @(negedge clk);
    check("R10 idle valid", int'(cost_valid), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule